// File: doc/BRIEF.md
# OTP Lock-Guarded Byte Access Port

This block sits between a request/response port and a 1024-byte antifuse one-time-programmable array. It serves byte reads and byte program requests. Every unprogrammed bit reads as 1, and programming can only move a bit to 0. The block therefore writes the AND of the stored byte and the requested byte, and it skips the array write when that AND would change nothing.

Accesses to the key area (0x200 to 0x35F) and to the two user regions (0x380 to 0x3BF and 0x3C0 to 0x3FF) are gated by lock bits. These lock bits live in bytes 0x364 to 0x367 of the same array. The block reads the four lock bytes live on every request, so a lock takes effect on the very next request after the program that cleared it.

Each request carries an address, a read/write flag, a data byte and a secure-world flag. The state machine has three states: S_IDLE, S_EVAL and S_RESP. S_IDLE moves to S_EVAL when a request is accepted (req_valid while req_ready). S_EVAL always moves to S_RESP; in this state the block reads the target byte, decides permission and performs any array write. S_RESP always returns to S_IDLE while presenting the response for one cycle.

Top module: `otp_guard`

## Requirements
- R1: A read of an unlocked address returns the stored byte with status OK (code 0). A byte never programmed reads 0xFF.
- R2: An allowed write whose AND with the stored byte differs from the stored byte stores that AND and returns it with status OK. No array write ever sets a bit.
- R3: A write whose AND equals the stored byte returns status NO-CHANGE (code 2) with the stored byte, and it performs no array write.
- R4: The lock word is the 32-bit value {byte 0x367, 0x366, 0x365, 0x364}. Key slot k (0 to 7, 32 bytes at 0x200+32k) is read-protected when lock bit 11+2k is 0 and write-forbidden when lock bit 12+2k is 0.
- R5: Lock bit 5 = 0 read-protects the password bytes 0x300 to 0x30F, and bit 6 = 0 write-forbids them. Bit 7 = 0 write-forbids the unique key 0x310 to 0x31F. Bits 9 and 10 = 0 write-forbid the hashes at 0x320 to 0x33F and 0x340 to 0x35F. Lock bits 5 and 6 leave the unique key unaffected.
- R6: While lock bit 30 (for 0x380 to 0x3BF) or lock bit 31 (for 0x3C0 to 0x3FF) is 1, both worlds may read and write that region. Once the bit is 0, a request with req_secure low is denied, and a request with req_secure high is still allowed.
- R7: A denied request returns data 0x00 with status DENIED (code 1). A denied write leaves the array unchanged. Addresses below 0x200 and the configuration bytes 0x360 to 0x37F are never denied.
- R8: A lock bit cleared by a write governs the next request, with no reset in between.
- R9: req_ready is high only in S_IDLE. rsp_valid is a single-cycle pulse on the second clock edge after acceptance, and req_ready is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = program, 0 = read |
| req_secure | input | 1 | Request comes from the secure world |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 8 | Byte to program (bits at 0 are cleared) |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 8 | Read byte, resulting byte, or 0x00 on denial |
| rsp_status | output | 2 | 0 OK, 1 DENIED, 2 NO-CHANGE |
| mem_addr | output | 10 | Array byte address |
| mem_rdata | input | 8 | Array byte at mem_addr (combinational) |
| mem_we | output | 1 | Array byte write strobe |
| mem_wdata | output | 8 | Array byte to store |
| lock_word | input | 32 | Live contents of array bytes 0x364 to 0x367 |

## Verification
The bench goes after the lock-bit index arithmetic at the slot edges (slot 0, slot 2, whose read and write bits straddle two bytes, and slot 7). An off-by-one design would deny the wrong slot or let a write into a forbidden one. It programs lock bytes and then immediately accesses the guarded range, which catches a design that caches locks. It also issues writes that clear no new bit, which exposes a design that wastes a write or reports OK. For the user regions it issues secure and non-secure requests before and after the active-low bit is cleared. A design with inverted polarity would lock the region from the start.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_DENIED = 2'd1,
        ST_NOCHG  = 2'd2
    } otp_status_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EVAL = 2'd1,
        S_RESP = 2'd2
    } otp_state_e;

    // region bases of the physical map
    localparam int unsigned KEY_BASE   = 'h200;
    localparam int unsigned PWD_BASE   = 'h300;
    localparam int unsigned UKEY_BASE  = 'h310;
    localparam int unsigned HASH1_BASE = 'h320;
    localparam int unsigned HASH2_BASE = 'h340;
    localparam int unsigned CFG_BASE   = 'h360;
    localparam int unsigned USR1_BASE  = 'h380;
    localparam int unsigned USR2_BASE  = 'h3C0;

    // bit positions inside the 32-bit lock word (bytes 0x364..0x367)
    localparam int unsigned PWD_RP    = 5;
    localparam int unsigned PWD_WF    = 6;
    localparam int unsigned UKEY_WF   = 7;
    localparam int unsigned HASH1_WF  = 9;
    localparam int unsigned HASH2_WF  = 10;
    localparam int unsigned SLOT_RP0  = 11;
    localparam int unsigned USR1_OPEN = 30;
    localparam int unsigned USR2_OPEN = 31;

endpackage

// File: rtl/otp_lock_decode.sv
module otp_lock_decode
    import otp_guard_pkg::*;
#(
    parameter int AW         = 10,
    parameter int LW         = 32,
    parameter int NUM_SLOTS  = 8,
    parameter int SLOT_BYTES = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          secure,
    input  logic [LW-1:0] lock_word,
    output logic          rd_deny,
    output logic          wr_deny
);
    localparam int SLOT_SH = $clog2(SLOT_BYTES);
    localparam int SLOT_W  = $clog2(NUM_SLOTS);
    localparam logic [AW-1:0] A_KEY   = AW'(KEY_BASE);
    localparam logic [AW-1:0] A_PWD   = AW'(PWD_BASE);
    localparam logic [AW-1:0] A_UKEY  = AW'(UKEY_BASE);
    localparam logic [AW-1:0] A_HASH1 = AW'(HASH1_BASE);
    localparam logic [AW-1:0] A_HASH2 = AW'(HASH2_BASE);
    localparam logic [AW-1:0] A_CFG   = AW'(CFG_BASE);
    localparam logic [AW-1:0] A_USR1  = AW'(USR1_BASE);
    localparam logic [AW-1:0] A_USR2  = AW'(USR2_BASE);

    logic [NUM_SLOTS-1:0] slot_rp;
    logic [NUM_SLOTS-1:0] slot_wf;
    logic [SLOT_W-1:0]    slot_idx;
    logic                 unused_lock;

    // a lock bit is active once programmed to 0
    generate
        for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
            assign slot_rp[k] = ~lock_word[SLOT_RP0 + 2*k];
            assign slot_wf[k] = ~lock_word[SLOT_RP0 + 2*k + 1];
        end
    endgenerate

    assign slot_idx    = addr[SLOT_SH +: SLOT_W];
    assign unused_lock = ^lock_word;

    always_comb begin
        rd_deny = 1'b0;
        wr_deny = 1'b0;
        if (addr >= A_KEY && addr < A_PWD) begin
            rd_deny = slot_rp[slot_idx];
            wr_deny = slot_wf[slot_idx];
        end else if (addr >= A_PWD && addr < A_UKEY) begin
            rd_deny = ~lock_word[PWD_RP];
            wr_deny = ~lock_word[PWD_WF];
        end else if (addr >= A_UKEY && addr < A_HASH1) begin
            wr_deny = ~lock_word[UKEY_WF];
        end else if (addr >= A_HASH1 && addr < A_HASH2) begin
            wr_deny = ~lock_word[HASH1_WF];
        end else if (addr >= A_HASH2 && addr < A_CFG) begin
            wr_deny = ~lock_word[HASH2_WF];
        end else if (addr >= A_USR1 && addr < A_USR2) begin
            rd_deny = ~secure & ~lock_word[USR1_OPEN];
            wr_deny = ~secure & ~lock_word[USR1_OPEN];
        end else if (addr >= A_USR2) begin
            rd_deny = ~secure & ~lock_word[USR2_OPEN];
            wr_deny = ~secure & ~lock_word[USR2_OPEN];
        end
    end

endmodule

// File: rtl/otp_prog_merge.sv
module otp_prog_merge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] stored,
    input  logic [DW-1:0] request,
    output logic [DW-1:0] merged,
    output logic          changed
);
    // antifuse cells only move from 1 to 0
    assign merged  = stored & request;
    assign changed = (merged != stored);
endmodule

// File: rtl/otp_guard.sv
module otp_guard
    import otp_guard_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 8,
    parameter int NUM_SLOTS  = 8,
    parameter int SLOT_BYTES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_secure,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic [1:0]      rsp_status,
    output logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    input  logic [4*DW-1:0] lock_word
);
    localparam int LW = 4 * DW;

    otp_state_e  state_q, state_nx;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_wdata;
    logic          cap_write;
    logic          cap_secure;
    logic [DW-1:0] rsp_data_q;
    otp_status_e   rsp_status_q;

    logic          rd_deny, wr_deny;
    logic [DW-1:0] merged;
    logic          changed;
    logic [DW-1:0] eval_data;
    otp_status_e   eval_status;

    otp_lock_decode #(
        .AW(AW), .LW(LW), .NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)
    ) u_lock (
        .addr      (cap_addr),
        .secure    (cap_secure),
        .lock_word (lock_word),
        .rd_deny   (rd_deny),
        .wr_deny   (wr_deny)
    );

    otp_prog_merge #(.DW(DW)) u_merge (
        .stored  (mem_rdata),
        .request (cap_wdata),
        .merged  (merged),
        .changed (changed)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_nx = S_EVAL;
            S_EVAL:  state_nx = S_RESP;
            S_RESP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr     <= '0;
            cap_wdata    <= '1;
            cap_write    <= 1'b0;
            cap_secure   <= 1'b0;
            rsp_data_q   <= '0;
            rsp_status_q <= ST_OK;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                cap_addr   <= req_addr;
                cap_wdata  <= req_wdata;
                cap_write  <= req_write;
                cap_secure <= req_secure;
            end
            if (state_q == S_EVAL) begin
                rsp_data_q   <= eval_data;
                rsp_status_q <= eval_status;
            end
        end
    end

    // permission and program decision
    always_comb begin
        eval_data   = mem_rdata;
        eval_status = ST_OK;
        if (cap_write) begin
            if (wr_deny) begin
                eval_data   = '0;
                eval_status = ST_DENIED;
            end else if (!changed) begin
                eval_status = ST_NOCHG;
            end else begin
                eval_data   = merged;
            end
        end else if (rd_deny) begin
            eval_data   = '0;
            eval_status = ST_DENIED;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        rsp_valid  = (state_q == S_RESP);
        rsp_data   = rsp_data_q;
        rsp_status = rsp_status_q;
        mem_addr   = cap_addr;
        mem_wdata  = merged;
        mem_we     = (state_q == S_EVAL) && cap_write && !wr_deny && changed;
    end

    AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_wdata & ~mem_rdata) == '0)); // R2
    AST_WRITE_REPORTS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (rsp_valid && rsp_status == 2'd0)); // R2
    AST_WRITE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata != mem_rdata)); // R3
    AST_DENIED_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1) |-> (rsp_data == '0)); // R7
    AST_RSP_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!rsp_valid ##1 rsp_valid)); // R9
    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

endmodule

// File: tb/otp_guard_bench.sv
module otp_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, mem_we;
    logic [7:0]  rsp_data, mem_rdata, mem_wdata;
    logic [1:0]  rsp_status;
    logic [9:0]  mem_addr;
    logic [31:0] lock_word;

    logic [7:0] ram  [0:1023];
    logic [7:0] refm [0:1023];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  run_chk  = 1'b0;
    bit  exp_valid = 1'b0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    otp_guard u_otp_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .lock_word(lock_word)
    );

    // antifuse array model: blank after reset, stores what the block writes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) ram[i] <= 8'hFF;
        end else if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = ram[mem_addr];
    assign lock_word = {ram['h367], ram['h366], ram['h365], ram['h364]};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of the array and the response strobe
    always @(negedge clk) begin
        if (run_chk) begin
            int bad;
            bad = -1;
            for (int i = 0; i < 1024; i++) if (ram[i] !== refm[i]) bad = i;
            chk(bad < 0, "R2,R7 array contents", bad, -1);
            chk(rsp_valid === exp_valid, "R9 rsp_valid per cycle", rsp_valid, exp_valid);
        end
    end

    function automatic void ref_locks(input int a, input bit sec, output bit rd, output bit wr);
        logic [31:0] lw;
        int k;
        lw = {refm['h367], refm['h366], refm['h365], refm['h364]};
        rd = 1'b0; wr = 1'b0;
        if (a >= 'h200 && a < 'h300) begin
            k  = (a - 'h200) / 32;
            rd = !lw[11 + 2*k];
            wr = !lw[12 + 2*k];
        end else if (a >= 'h300 && a < 'h310) begin
            rd = !lw[5]; wr = !lw[6];
        end else if (a >= 'h310 && a < 'h320) begin
            wr = !lw[7];
        end else if (a >= 'h320 && a < 'h340) begin
            wr = !lw[9];
        end else if (a >= 'h340 && a < 'h360) begin
            wr = !lw[10];
        end else if (a >= 'h380 && a < 'h3C0) begin
            rd = !sec && !lw[30]; wr = rd;
        end else if (a >= 'h3C0) begin
            rd = !sec && !lw[31]; wr = rd;
        end
    endfunction

    task automatic xfer(input bit wr, input bit sec, input int a, input int d, input string tag);
        bit rd_dn, wr_dn, upd;
        int old, nv, e_data, e_stat;
        ref_locks(a, sec, rd_dn, wr_dn);
        old = refm[a];
        upd = 1'b0;
        if (wr) begin
            nv = old & d;
            if (wr_dn)          begin e_data = 0;   e_stat = 1; end
            else if (nv == old) begin e_data = old; e_stat = 2; end
            else                begin e_data = nv;  e_stat = 0; upd = 1'b1; end
        end else begin
            nv = old;
            if (rd_dn) begin e_data = 0;   e_stat = 1; end
            else       begin e_data = old; e_stat = 0; end
        end
        chk(req_ready === 1'b1, "R9 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_secure = sec;
        req_addr = 10'(a); req_wdata = 8'(d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0, "R9 ready low while busy", req_ready, 0);
        @(posedge clk);
        if (upd) refm[a] = 8'(nv);
        exp_valid = 1'b1;
        @(negedge clk);
        chk(rsp_data === 8'(e_data), {tag, " rsp_data"}, rsp_data, e_data);
        chk(rsp_status === 2'(e_stat), {tag, " rsp_status"}, rsp_status, e_stat);
        chk(ram[a] === refm[a], {tag, " stored byte"}, ram[a], refm[a]);
        @(posedge clk);
        exp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < 1024; i++) refm[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R9 reset rsp_valid", rsp_valid, 0);
        chk(req_ready === 1'b1, "R9 reset req_ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        run_chk = 1'b1;

        // R1 blank and plain reads, R2 AND programming, R3 wasted program
        xfer(0, 0, 'h000, 'h00, "R1 blank read");
        xfer(1, 0, 'h010, 'h3C, "R2 first program");
        xfer(1, 0, 'h010, 'hF0, "R2 AND merge");
        xfer(0, 0, 'h010, 'h00, "R1 read back");
        xfer(1, 0, 'h010, 'hFF, "R3 all ones");
        xfer(1, 0, 'h010, 'h30, "R3 same value");

        // R4 key slots, R7 denial, R8 immediate effect
        xfer(1, 0, 'h265, 'h5A, "R4 slot3 open write");
        xfer(1, 0, 'h366, 'hFE, "R4 slot2 write-forbid");
        xfer(1, 0, 'h241, 'h00, "R7 denied write slot2");
        xfer(0, 0, 'h241, 'h00, "R7 slot2 unchanged");
        xfer(1, 0, 'h366, 'hFD, "R8 slot3 read-protect");
        xfer(0, 0, 'h265, 'h00, "R8 slot3 read denied");
        xfer(1, 0, 'h265, 'h00, "R4 slot3 still writable");
        xfer(1, 0, 'h367, 'hFB, "R4 slot7 write-forbid");
        xfer(1, 0, 'h2E0, 'h00, "R4 slot7 write denied");
        xfer(0, 0, 'h2E0, 'h00, "R4 slot7 readable");
        xfer(1, 0, 'h365, 'hF7, "R4 slot0 read-protect");
        xfer(0, 1, 'h200, 'h00, "R4 slot0 read denied");
        xfer(0, 0, 'h220, 'h00, "R4 slot1 unaffected");

        // R5 password, unique key, hashes
        xfer(1, 0, 'h364, 'hDF, "R5 password read-protect");
        xfer(0, 1, 'h305, 'h00, "R5 password read denied");
        xfer(1, 0, 'h305, 'h0F, "R5 password still writable");
        xfer(1, 0, 'h364, 'h7F, "R5 unique key write-forbid");
        xfer(1, 0, 'h312, 'h00, "R5 unique key write denied");
        xfer(0, 0, 'h312, 'h00, "R5 unique key readable");
        xfer(1, 0, 'h365, 'hFD, "R5 hash1 write-forbid");
        xfer(1, 0, 'h321, 'h00, "R5 hash1 write denied");
        xfer(1, 0, 'h341, 'h12, "R5 hash2 open");

        // R6 user regions, active-low secure-only bits
        xfer(1, 0, 'h390, 'hAA, "R6 region1 open write");
        xfer(1, 0, 'h367, 'hBF, "R6 region1 lock");
        xfer(0, 0, 'h390, 'h00, "R6 region1 nonsecure read");
        xfer(0, 1, 'h390, 'h00, "R6 region1 secure read");
        xfer(1, 0, 'h3C5, 'h11, "R6 region2 still open");
        xfer(1, 0, 'h367, 'h7F, "R6 region2 lock");
        xfer(1, 0, 'h3C5, 'h00, "R6 region2 nonsecure write");
        xfer(1, 1, 'h3C5, 'h00, "R6 region2 secure write");

        // R7 unrestricted ranges
        xfer(1, 0, 'h1FF, 'h00, "R7 low area open");
        xfer(0, 0, 'h37C, 'h00, "R7 config area open");

        run_chk = 1'b0;
        summary();
    end

endmodule